// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and arbitrates among four interrupt sources: one non-maskable source, two maskable level-sensitive sources with fixed internal vectors (a high one and a middle one), and one general external source whose vector is supplied by the requesting device. Requests are only weighed when the core marks an instruction boundary. The winner is latched and a service request, with its vector, is held toward the core until the core acknowledges it.

The non-maskable input is edge-qualified: it is recorded only when a low-to-high change is followed by a sustained high level. The record then stays pending until its own service is acknowledged. The maskable sources obey a global enable flag and one mask bit each. The external source obeys only the global enable. After the core acknowledges an external-source service, the block drives an active-low acknowledge strobe for one clock so that the device can place its vector on the bus. Accepting any request clears the global enable.

Control state machine:
- `ST_IDLE`: waits. At a boundary with something pending it takes the transition *accept* to `ST_REQ`.
- `ST_REQ`: holds the request and the vector. On acknowledge it takes *ack_ext* to `ST_INTA` when the external source won, or *ack_int* back to `ST_IDLE` otherwise.
- `ST_INTA`: drives the strobe for one cycle, then takes *strobe_done* to `ST_IDLE`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `svc_req_o` is 0, `svc_vec_o` is 0, `inta_n_o` is 1, the global enable is off, both mask bits are set (masked), and no non-maskable event is pending.
- R2: When several sources are pending at an accepting boundary, the winner is, in order: non-maskable, high, middle, external.
- R3: The vectors are 0x0024 for the non-maskable source, 0x0034 for the high source and 0x002C for the middle source. For the external source `svc_vec_o` is 0x0000 and `svc_ext_o` is 1; `svc_ext_o` is 0 for the other sources.
- R4: A non-maskable event is recorded only when `nmi_i` is sampled high on 2 consecutive rising clock edges, the first of which follows a low sample. A single-cycle pulse is ignored. Holding the input high never records a second event.
- R5: A recorded non-maskable event is serviced whatever the state of the global enable and the masks.
- R6: The high and middle sources are level sensitive. Each is taken only if its input is high at the boundary edge, the global enable is on, and its own mask bit is 0. `mask_i[1]` masks the high source, `mask_i[0]` masks the middle source, and 1 means masked. `mask_wr_i` loads both bits.
- R7: The external source needs only the global enable; the mask bits do not affect it. After `svc_ack_i` ends an external-source service, `inta_n_o` is low for exactly one clock.
- R8: `ien_set_i` turns the global enable on and `ien_clr_i` turns it off. Accepting any request turns it off, and this takes precedence over both.
- R9: Pending sources are evaluated only in cycles where `boundary_i` is 1. Without a boundary, no request is raised.
- R10: `svc_req_o` rises one clock after the accepting boundary edge. It then holds, with `svc_vec_o` and `svc_ext_o` stable, until `svc_ack_i` is sampled. Boundaries seen meanwhile have no effect.
- R11: A recorded non-maskable event stays pending until the acknowledge of its own service, and is cleared then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable interrupt input |
| irq_hi_i | input | 1 | Maskable high-priority level request |
| irq_mid_i | input | 1 | Maskable middle-priority level request |
| irq_ext_i | input | 1 | General external request, vector from the device |
| ien_set_i | input | 1 | Enable-interrupts instruction strobe |
| ien_clr_i | input | 1 | Disable-interrupts instruction strobe |
| mask_wr_i | input | 1 | Load the mask bits |
| mask_i | input | 2 | Mask bits: [1] high source, [0] middle source, 1 = masked |
| boundary_i | input | 1 | Core is at an instruction boundary |
| svc_ack_i | input | 1 | Core accepts the held service request |
| svc_req_o | output | 1 | Service request to the core |
| svc_vec_o | output | ADDR_W | Vector of the held request |
| svc_ext_o | output | 1 | Held request is external; the device supplies the vector |
| inta_n_o | output | 1 | Active-low acknowledge strobe to the external device |

## Verification
A corrupted enable flag or mask bit shows up at the very next boundary: a request is raised that should not be, or one is missing, one clock after that boundary edge. A wrong non-maskable qualifier shows up as a service appearing after a single-cycle pulse or after a held level, or as a vector of 0x0024 missing at the first boundary after a valid two-cycle high. A control state that is out of step shows on the cycle after an acknowledge, as a strobe that is missing, doubled or misplaced. The bench's behavioural model is compared against all four outputs on every clock, so any such error is reported in the cycle it first reaches a port.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NSRC = 4;

    // Encoding doubles as priority rank: larger value wins.
    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_MID = 2'd1,
        SRC_HI  = 2'd2,
        SRC_NMI = 2'd3
    } irq_src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_INTA = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/prio_irq_nmi_qual.sv
module prio_irq_nmi_qual #(
    parameter int NMI_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic clr_i,
    output logic pend_o
);
    localparam int CW = $clog2(NMI_HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(NMI_HOLD);

    logic          prev_q;
    logic          armed_q;
    logic [CW-1:0] run_q;
    logic          hit;

    assign hit = nmi_i && prev_q && armed_q && (run_q + CW'(1) == HOLD_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            run_q   <= '0;
        end else begin
            prev_q <= nmi_i;
            if (!nmi_i) begin
                armed_q <= 1'b0;
                run_q   <= '0;
            end else if (!prev_q) begin
                armed_q <= 1'b1;
                run_q   <= CW'(1);
            end else if (armed_q) begin
                run_q <= run_q + CW'(1);
                if (hit) armed_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_o <= 1'b0;
        else if (hit)    pend_o <= 1'b1;
        else if (clr_i)  pend_o <= 1'b0;
    end

    // R4: a new record needs the input high on the two edges before it
    assert_nmi_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> ($past(nmi_i) && $past(nmi_i, 2)));

    // R11: a record is only dropped by its own acknowledge
    assert_nmi_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/prio_irq_enable.sv
module prio_irq_enable #(
    parameter int MASK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              accept_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              ien_o,
    output logic [MASK_W-1:0] mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ien_o <= 1'b0;
        else if (accept_i) ien_o <= 1'b0;
        else if (clr_i)    ien_o <= 1'b0;
        else if (set_i)    ien_o <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_o <= '1;
        else if (mask_wr_i) mask_o <= mask_i;
    end

    // R8: acceptance always leaves the enable off
    assert_accept_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !ien_o);
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    output logic [NSRC-1:0] grant_o,
    output irq_src_e        src_o
);
    // Higher index means higher priority.
    for (genvar i = 0; i < NSRC; i++) begin : g_grant
        if (i == NSRC - 1) begin : g_top
            assign grant_o[i] = pend_i[i];
        end else begin : g_low
            assign grant_o[i] = pend_i[i] && !(|pend_i[NSRC-1:i+1]);
        end
    end

    always_comb begin
        src_o = SRC_EXT;
        for (int k = 0; k < NSRC; k++) begin
            if (grant_o[k]) src_o = irq_src_e'(k);
        end
    end

    // R2: at most one winner, and one whenever anything is pending
    always_comb begin
        assert_grant_onehot_R2: assert ($onehot0(grant_o));
        assert_grant_present_R2: assert ((|pend_i) == (|grant_o));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NMI_HOLD = 2,
    parameter logic [ADDR_W-1:0] VEC_NMI  = 16'h0024,
    parameter logic [ADDR_W-1:0] VEC_HI   = 16'h0034,
    parameter logic [ADDR_W-1:0] VEC_MID  = 16'h002C,
    parameter logic [ADDR_W-1:0] VEC_EXT  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_i,
    input  logic              irq_hi_i,
    input  logic              irq_mid_i,
    input  logic              irq_ext_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic              mask_wr_i,
    input  logic [1:0]        mask_i,
    input  logic              boundary_i,
    input  logic              svc_ack_i,
    output logic              svc_req_o,
    output logic [ADDR_W-1:0] svc_vec_o,
    output logic              svc_ext_o,
    output logic              inta_n_o
);
    logic            nmi_pend;
    logic            ien;
    logic [1:0]      mask;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] grant;
    irq_src_e        win_src;
    irq_src_e        src_q;
    logic [ADDR_W-1:0] vec_q;
    logic [ADDR_W-1:0] win_vec;
    ctl_state_e      state_q;
    ctl_state_e      state_n;
    logic            accept;
    logic            nmi_clr;

    prio_irq_nmi_qual #(.NMI_HOLD(NMI_HOLD)) u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    prio_irq_enable #(.MASK_W(2)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (ien_set_i),
        .clr_i     (ien_clr_i),
        .accept_i  (accept),
        .mask_wr_i (mask_wr_i),
        .mask_i    (mask_i),
        .ien_o     (ien),
        .mask_o    (mask)
    );

    assign pend[SRC_NMI] = nmi_pend;
    assign pend[SRC_HI]  = irq_hi_i  && ien && !mask[1];
    assign pend[SRC_MID] = irq_mid_i && ien && !mask[0];
    assign pend[SRC_EXT] = irq_ext_i && ien;

    prio_irq_arb u_arb (
        .pend_i  (pend),
        .grant_o (grant),
        .src_o   (win_src)
    );

    always_comb begin
        unique case (win_src)
            SRC_NMI: win_vec = VEC_NMI;
            SRC_HI:  win_vec = VEC_HI;
            SRC_MID: win_vec = VEC_MID;
            default: win_vec = VEC_EXT;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && boundary_i && (|grant);
    assign nmi_clr = (state_q == ST_REQ) && svc_ack_i && (src_q == SRC_NMI);

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_n = ST_REQ;
            ST_REQ:  if (svc_ack_i) state_n = (src_q == SRC_EXT) ? ST_INTA : ST_IDLE;
            ST_INTA: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and captured winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_EXT;
            vec_q   <= '0;
        end else begin
            state_q <= state_n;
            if (accept) begin
                src_q <= win_src;
                vec_q <= win_vec;
            end
        end
    end

    // Outputs
    always_comb begin
        svc_req_o = (state_q == ST_REQ);
        svc_vec_o = (state_q == ST_REQ) ? vec_q : '0;
        svc_ext_o = (state_q == ST_REQ) && (src_q == SRC_EXT);
        inta_n_o  = (state_q != ST_INTA);
    end

    // R9: a request only starts after a boundary
    assert_req_after_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_req_o) |-> $past(boundary_i));

    // R10: the vector is held while the request waits
    assert_vec_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req_o && $past(svc_req_o)) |-> ($stable(svc_vec_o) && $stable(svc_ext_o)));

    // R7: the strobe lasts one clock
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |=> inta_n_o);

    // R7: the strobe follows an acknowledged external service
    assert_strobe_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inta_n_o) |-> $past(svc_ack_i && svc_req_o && svc_ext_o));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi = 0, hi = 0, mid = 0, ext = 0;
    logic eset = 0, eclr = 0, mwr = 0, bnd = 0, ack = 0;
    logic [1:0] mval = 2'b00;
    logic svc_req, svc_ext, inta_n;
    logic [15:0] svc_vec;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_hi_i(hi), .irq_mid_i(mid),
        .irq_ext_i(ext), .ien_set_i(eset), .ien_clr_i(eclr), .mask_wr_i(mwr),
        .mask_i(mval), .boundary_i(bnd), .svc_ack_i(ack), .svc_req_o(svc_req),
        .svc_vec_o(svc_vec), .svc_ext_o(svc_ext), .inta_n_o(inta_n)
    );

    // Behavioural reference model
    int m_prev, m_arm, m_run, m_lat, m_ien, m_mask, m_st, m_src, m_vec;
    int n_st, n_acc, n_clr, n_set;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_arm = 0; m_run = 0; m_lat = 0; m_ien = 0;
            m_mask = 3; m_st = 0; m_src = 0; m_vec = 0;
        end else begin
            n_st = m_st; n_acc = 0; n_clr = 0; n_set = 0;
            if (!nmi) begin m_arm = 0; m_run = 0; end
            else if (m_prev == 0) begin m_arm = 1; m_run = 1; end
            else if (m_arm == 1) begin
                m_run = m_run + 1;
                if (m_run == 2) begin n_set = 1; m_arm = 0; end
            end
            m_prev = nmi;
            if (m_st == 0) begin
                if (bnd) begin
                    if (m_lat == 1) begin n_acc = 1; m_src = 3; m_vec = 16'h0024; end
                    else if (hi && m_ien == 1 && (m_mask & 2) == 0) begin n_acc = 1; m_src = 2; m_vec = 16'h0034; end
                    else if (mid && m_ien == 1 && (m_mask & 1) == 0) begin n_acc = 1; m_src = 1; m_vec = 16'h002C; end
                    else if (ext && m_ien == 1) begin n_acc = 1; m_src = 0; m_vec = 0; end
                    if (n_acc == 1) n_st = 1;
                end
            end else if (m_st == 1) begin
                if (ack) begin
                    if (m_src == 3) n_clr = 1;
                    n_st = (m_src == 0) ? 2 : 0;
                end
            end else begin
                n_st = 0;
            end
            m_st = n_st;
            if (n_set == 1) m_lat = 1; else if (n_clr == 1) m_lat = 0;
            if (n_acc == 1) m_ien = 0; else if (eclr) m_ien = 0; else if (eset) m_ien = 1;
            if (mwr) m_mask = mval;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (svc_req !== (m_st == 1)) begin
                failures++;
                $display("FAIL R10 model svc_req actual=%0d expected=%0d cycle=%0d", svc_req, m_st == 1, cyc);
            end
            if (inta_n !== (m_st != 2)) begin
                failures++;
                $display("FAIL R7 model inta_n actual=%0d expected=%0d cycle=%0d", inta_n, m_st != 2, cyc);
            end
            if (m_st == 1) begin
                if (svc_vec !== 16'(m_vec) || svc_ext !== (m_src == 0)) begin
                    failures++;
                    $display("FAIL R3 model vec/ext actual=%h/%0d expected=%h/%0d cycle=%0d",
                             svc_vec, svc_ext, 16'(m_vec), m_src == 0, cyc);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=5000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic boundary();
        bnd = 1; @(negedge clk); bnd = 0;
    endtask

    task automatic do_ack();
        ack = 1; @(negedge clk); ack = 0;
    endtask

    task automatic enable();
        eset = 1; @(negedge clk); eset = 0;
    endtask

    task automatic set_mask(input logic [1:0] v);
        mwr = 1; mval = v; @(negedge clk); mwr = 0;
    endtask

    initial begin
        tick(3);
        chk(svc_req == 0, "R1 reset req", svc_req, 0);
        chk(inta_n == 1, "R1 reset inta_n", inta_n, 1);
        chk(svc_vec == 0, "R1 reset vec", svc_vec, 0);
        rst_n = 1;
        tick(2);

        // R1: masks start set, so the high source is refused after enable
        enable();
        hi = 1;
        boundary();
        chk(svc_req == 0, "R1 reset masks", svc_req, 0);

        // R9: no boundary, no request
        set_mask(2'b00);
        tick(3);
        chk(svc_req == 0, "R9 no boundary", svc_req, 0);
        boundary();
        chk(svc_req == 1, "R6 high accepted", svc_req, 1);
        chk(svc_vec == 16'h0034, "R3 high vector", svc_vec, 16'h0034);
        chk(svc_ext == 0, "R3 high not ext", svc_ext, 0);

        // R10: boundaries and other sources ignored while held
        mid = 1;
        boundary();
        tick(2);
        chk(svc_req == 1 && svc_vec == 16'h0034, "R10 held request", svc_vec, 16'h0034);
        do_ack();
        chk(svc_req == 0, "R10 request drops on ack", svc_req, 0);

        // R8: acceptance cleared the enable
        boundary();
        chk(svc_req == 0, "R8 enable cleared by accept", svc_req, 0);
        enable();
        eclr = 1; @(negedge clk); eclr = 0;
        boundary();
        chk(svc_req == 0, "R8 disable strobe", svc_req, 0);

        // R2: priority high > middle > external
        ext = 1;
        enable();
        boundary();
        chk(svc_vec == 16'h0034, "R2 high over middle", svc_vec, 16'h0034);
        do_ack();
        hi = 0;
        enable();
        boundary();
        chk(svc_vec == 16'h002C, "R2 middle over external", svc_vec, 16'h002C);
        do_ack();
        mid = 0;
        enable();
        boundary();
        chk(svc_req == 1 && svc_ext == 1, "R3 external selected", svc_ext, 1);
        chk(svc_vec == 16'h0000, "R3 external vector", svc_vec, 0);
        do_ack();
        chk(inta_n == 0, "R7 strobe low", inta_n, 0);
        tick(1);
        chk(inta_n == 1, "R7 strobe one cycle", inta_n, 1);
        ext = 0;

        // R6: mask bits
        set_mask(2'b10);
        hi = 1;
        enable();
        boundary();
        chk(svc_req == 0, "R6 high masked by bit1", svc_req, 0);
        hi = 0; mid = 1;
        set_mask(2'b01);
        boundary();
        chk(svc_req == 0, "R6 middle masked by bit0", svc_req, 0);
        mid = 0;

        // R7: external ignores masks
        set_mask(2'b11);
        ext = 1;
        boundary();
        chk(svc_req == 1 && svc_ext == 1, "R7 external unmasked", svc_req, 1);
        do_ack();
        tick(1);
        ext = 0;

        // R4: single-cycle pulse ignored
        nmi = 1; tick(1); nmi = 0;
        tick(2);
        boundary();
        chk(svc_req == 0, "R4 pulse ignored", svc_req, 0);

        // R4/R5: two-cycle high recorded, enable off and masks set
        nmi = 1; tick(2);
        boundary();
        chk(svc_vec == 16'h0024 && svc_req == 1, "R5 nmi despite masks", svc_vec, 16'h0024);
        do_ack();
        tick(2);
        boundary();
        chk(svc_req == 0, "R4 held level no retrigger", svc_req, 0);
        nmi = 0;

        // R11: record waits until serviced, wins over external
        tick(1);
        nmi = 1; tick(3); nmi = 0;
        tick(5);
        ext = 1;
        enable();
        boundary();
        chk(svc_vec == 16'h0024, "R11 record kept, R2 nmi first", svc_vec, 16'h0024);
        do_ack();
        enable();
        boundary();
        chk(svc_req == 1 && svc_ext == 1, "R11 record cleared by ack", svc_ext, 1);
        do_ack();
        ext = 0;
        tick(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule